// File: doc/BRIEF.md
# Hardware-Managed Free Message Queue

This block keeps a circular queue of message entries in local memory. A host-side agent writes a message to one fixed queue port. The block turns that bus write into a memory write at the address held in a head pointer. Once memory confirms the write, the hardware advances the head pointer by one 4-byte entry.

A local processor consumes entries starting at the tail pointer. It reads the entry at the tail address itself and then moves the tail forward through a register write. No hardware path ever changes the tail.

Both pointers wrap inside a power-of-two region that starts at a base address. A port write that arrives while a previous write is still in flight is answered with a retry, and so is one that arrives while the queue is full. A queue that fills up sets a sticky status bit, and a mask bit decides whether that status bit reaches the interrupt output.

Top module: `free_msg_queue`

## Requirements
- R1: A port write that arrives while the block is idle and the queue is not full is accepted (`bus_ack` high in the same cycle). Starting the next cycle, `mem_req` is held high with `mem_addr` equal to the head pointer at acceptance and `mem_wdata` equal to the written data, and both stay stable until the cycle in which `mem_ack` is high.
- R2: The head pointer keeps its old value in the cycle in which `mem_ack` is high. It reads one entry (4 bytes) further from the next cycle onward.
- R3: From acceptance until the head pointer has advanced, any port write receives `bus_retry` and never `bus_ack`.
- R4: When a hardware head advance makes the head equal to the tail, the queue becomes full. Status register bit 0 (full event) and bit 1 (full flag) then read 1.
- R5: Status bit 0 is sticky. It clears only when software writes 1 to status bit 0. Writing the head pointer or the tail pointer never clears it.
- R6: `irq` equals status bit 0 AND NOT mask bit 0. The mask bit is 1 out of reset. The status bit records a full event while it is masked.
- R7: While the full flag is set, every port write is retried, and the head pointer and memory stay unchanged.
- R8: Pointers advance by 4 and wrap within a 2^QLOG2-byte region at QBASE. On a register write to a pointer, the bits above the region are forced to QBASE and bits [1:0] are forced to 0.
- R9: A head value loaded by software is the address used for the next accepted port write.
- R10: Only register writes change the tail pointer. Any pointer register write that leaves the head different from the tail clears the full flag.
- R11: Reset state: the head and tail pointers read QBASE, the status register reads 0, the mask reads 1, and `mem_req` and `irq` are low.
- R12: Register map (`reg_addr`): 0 = head pointer, 1 = tail pointer, 2 = status ({full flag, full event}), 3 = mask (bit 0). `reg_rdata` is combinational on `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Write request to the queue port |
| bus_wdata | input | DATA_W | Message data for the queue port |
| bus_ack | output | 1 | Port write accepted this cycle |
| bus_retry | output | 1 | Port write refused, try again |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory write done |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data |
| irq | output | 1 | Queue-full interrupt |

## Verification
A corrupted head pointer shows up as a wrong `mem_addr` on the next accepted write, and as a wrong readback of register 0 one cycle after `mem_ack`. A wrong full flag shows up within a single cycle: the block either retries a port write when the queue has room, or acknowledges one into a full queue. A status bit that is lost or cleared by mistake is visible on `irq` and on register 2 in the cycle after the event or pointer write. The bench walks the full ring with varied memory latencies, so every wrap position and every in-flight window is covered.

// File: rtl/fmq_pkg.sv
package fmq_pkg;
  typedef enum logic {WR_IDLE, WR_BUSY} wr_state_e;
  localparam logic [1:0] REG_HEAD = 2'd0;
  localparam logic [1:0] REG_TAIL = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_MASK = 2'd3;
endpackage

// File: rtl/fmq_writer.sv
module fmq_writer
  import fmq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              q_full,
  input  logic [ADDR_W-1:0] head_ptr,
  input  logic              mem_ack,
  output logic              bus_ack,
  output logic              bus_retry,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              head_adv
);
  wr_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;

  always_comb begin
    accept   = bus_req && (state_q == WR_IDLE) && !q_full;
    head_adv = (state_q == WR_BUSY) && mem_ack;
    state_d  = state_q;
    if (accept)   state_d = WR_BUSY;
    if (head_adv) state_d = WR_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WR_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q <= head_ptr;
        data_q <= bus_wdata;
      end
    end
  end

  assign bus_ack   = accept;
  assign bus_retry = bus_req && !accept;
  assign mem_req   = (state_q == WR_BUSY);
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
endmodule

// File: rtl/fmq_regs.sv
module fmq_regs
  import fmq_pkg::*;
#(
  parameter int          ADDR_W = 32,
  parameter int          QLOG2  = 6,
  parameter logic [31:0] QBASE  = 32'h0000_2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              head_adv,
  output logic [ADDR_W-1:0] head_ptr,
  output logic [ADDR_W-1:0] tail_ptr,
  output logic              q_full,
  output logic              int_stat,
  output logic              int_mask,
  output logic [ADDR_W-1:0] reg_rdata
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(QBASE);
  localparam logic [QLOG2-1:0]  STEP = QLOG2'(4);

  logic [ADDR_W-1:0] head_q, head_d, tail_q, tail_d, bumped, fitted;
  logic              full_q, full_d, stat_q, stat_d, mask_q, mask_d;
  logic              wr_head, wr_tail, wr_stat, wr_mask, hit;
  logic              unused_wdata;

  assign unused_wdata = ^{reg_wdata[ADDR_W-1:QLOG2], reg_wdata[1:0]};

  always_comb begin
    wr_head = reg_wr && (reg_addr == REG_HEAD);
    wr_tail = reg_wr && (reg_addr == REG_TAIL);
    wr_stat = reg_wr && (reg_addr == REG_STAT);
    wr_mask = reg_wr && (reg_addr == REG_MASK);
    fitted  = {BASE[ADDR_W-1:QLOG2], reg_wdata[QLOG2-1:2], 2'b00};
    bumped  = {head_q[ADDR_W-1:QLOG2], head_q[QLOG2-1:0] + STEP};

    head_d = head_q;
    if (wr_head)       head_d = fitted;
    else if (head_adv) head_d = bumped;
    tail_d = wr_tail ? fitted : tail_q;

    hit    = head_adv && !wr_head && (bumped == tail_d);
    full_d = full_q;
    if (hit)                                         full_d = 1'b1;
    else if ((wr_head || wr_tail) && head_d != tail_d) full_d = 1'b0;

    stat_d = stat_q;
    if (hit)                         stat_d = 1'b1;
    else if (wr_stat && reg_wdata[0]) stat_d = 1'b0;
    mask_d = wr_mask ? reg_wdata[0] : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= BASE;
      tail_q <= BASE;
      full_q <= 1'b0;
      stat_q <= 1'b0;
      mask_q <= 1'b1;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      full_q <= full_d;
      stat_q <= stat_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    unique case (reg_addr)
      REG_HEAD: reg_rdata = head_q;
      REG_TAIL: reg_rdata = tail_q;
      REG_STAT: reg_rdata = {{(ADDR_W-2){1'b0}}, full_q, stat_q};
      default:  reg_rdata = {{(ADDR_W-1){1'b0}}, mask_q};
    endcase
  end

  assign head_ptr = head_q;
  assign tail_ptr = tail_q;
  assign q_full   = full_q;
  assign int_stat = stat_q;
  assign int_mask = mask_q;
endmodule

// File: rtl/free_msg_queue.sv
module free_msg_queue #(
  parameter int          ADDR_W = 32,
  parameter int          DATA_W = 32,
  parameter int          QLOG2  = 6,
  parameter logic [31:0] QBASE  = 32'h0000_2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ack,
  output logic              bus_retry,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              irq
);
  logic [ADDR_W-1:0] head_q, tail_q;
  logic              full_q, stat_q, mask_q, head_adv;

  fmq_writer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_writer (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wdata(bus_wdata),
    .q_full(full_q), .head_ptr(head_q), .mem_ack(mem_ack),
    .bus_ack(bus_ack), .bus_retry(bus_retry), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .head_adv(head_adv)
  );

  fmq_regs #(.ADDR_W(ADDR_W), .QLOG2(QLOG2), .QBASE(QBASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .head_adv(head_adv), .head_ptr(head_q),
    .tail_ptr(tail_q), .q_full(full_q), .int_stat(stat_q),
    .int_mask(mask_q), .reg_rdata(reg_rdata)
  );

  assign irq = stat_q && !mask_q;
endmodule

// File: rtl/fmq_checker.sv
module fmq_checker #(
  parameter int          ADDR_W = 32,
  parameter int          DATA_W = 32,
  parameter int          QLOG2  = 6,
  parameter logic [31:0] QBASE  = 32'h0000_2000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_ack,
  input logic              bus_retry,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [ADDR_W-1:0] reg_wdata,
  input logic [ADDR_W-1:0] head_q,
  input logic [ADDR_W-1:0] tail_q,
  input logic              full_q,
  input logic              stat_q,
  input logic              mask_q,
  input logic              irq
);
  localparam logic [ADDR_W-1:0] LOWM = ADDR_W'((1 << QLOG2) - 1);
  logic [ADDR_W-1:0] head_plus;
  assign head_plus = (head_q & ~LOWM) | ((head_q + ADDR_W'(4)) & LOWM);

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata)); // R1
  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !(reg_wr && reg_addr == 2'd0) |=> head_q == $past(head_plus)); // R2
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ack && !reg_wr |=> $stable(head_q)); // R2
  AST_RETRY_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && bus_req |-> bus_retry && !bus_ack); // R3
  AST_STICKY_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q && !(reg_wr && reg_addr == 2'd2 && reg_wdata[0]) |=> stat_q); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> !irq); // R6
  AST_FULL_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && bus_req |-> bus_retry && !bus_ack); // R7
  AST_TAIL_SW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 2'd1) |=> $stable(tail_q)); // R10
  AST_ACK_XOR_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_ack && bus_retry)); // R3
endmodule

bind free_msg_queue fmq_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .QLOG2(QLOG2), .QBASE(QBASE)
) u_fmq_checker (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ack(bus_ack),
  .bus_retry(bus_retry), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .head_q(head_q),
  .tail_q(tail_q), .full_q(full_q), .stat_q(stat_q), .mask_q(mask_q),
  .irq(irq)
);

// File: tb/test_free_msg_queue.sv
module test_free_msg_queue;
  localparam int          AW    = 32;
  localparam int          DW    = 32;
  localparam int          QLOG2 = 6;
  localparam logic [31:0] BASE  = 32'h0000_2000;
  localparam int          NENT  = (1 << QLOG2) / 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_req = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_ack, bus_retry, mem_req, irq;
  logic [AW-1:0] mem_addr, reg_rdata;
  logic [DW-1:0] mem_wdata;
  logic          mem_ack = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [AW-1:0] reg_wdata = '0;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int cnt = 0;
  bit done = 1'b0;
  logic [DW-1:0] mem [NENT];
  logic [AW-1:0] mh, mt;

  always #10 clk = ~clk;

  free_msg_queue #(.ADDR_W(AW), .DATA_W(DW), .QLOG2(QLOG2), .QBASE(BASE)) i_free_msg_queue (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_retry(bus_retry), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // memory model: acknowledge after lat waiting cycles
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      if (cnt >= lat) begin mem_ack = 1'b1; cnt = 0; end
      else cnt = cnt + 1;
    end else mem_ack = 1'b0;
  end
  always @(posedge clk) if (mem_req && mem_ack) mem[mem_addr[QLOG2-1:2]] <= mem_wdata;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p & ~AW'((1 << QLOG2) - 1)) | ((p + 4) & AW'((1 << QLOG2) - 1));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [AW-1:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [AW-1:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; #1;
  endtask

  task automatic push(input logic [DW-1:0] d, input int l);
    logic [AW-1:0] v;
    lat = l;
    @(negedge clk); bus_req = 1'b1; bus_wdata = d; #1;
    chk("R1 accept", {31'b0, bus_ack}, 32'd1);
    @(negedge clk); bus_req = 1'b1; bus_wdata = ~d; #1;
    chk("R3 retry in flight", {30'b0, bus_retry, bus_ack}, 32'd2);
    bus_req = 1'b0;
    chk("R1 addr", mem_addr, mh);
    chk("R1 data", mem_wdata, d);
    while (!mem_ack) begin @(negedge clk); #1; end
    rd(2'd0, v); chk("R2 head old at ack", v, mh);
    @(negedge clk); #1;
    mh = step(mh);
    rd(2'd0, v); chk("R2 head advanced", v, mh);
    chk("R1 memory", mem[mem_addr[QLOG2-1:2]], d);
  endtask

  initial begin
    logic [AW-1:0] v;
    mh = BASE; mt = BASE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    rd(2'd0, v); chk("R11 head", v, BASE);
    rd(2'd1, v); chk("R11 tail", v, BASE);
    rd(2'd2, v); chk("R11 status", v, 32'd0);
    rd(2'd3, v); chk("R11 mask", v, 32'd1);
    chk("R11 mem_req irq", {30'b0, mem_req, irq}, 32'd0);

    wr(2'd3, 32'd0);
    for (int i = 0; i < NENT; i++) begin
      push(32'hA500_0000 + i * 7, i % 4);
      rd(2'd2, v);
      chk("R4 full after fill", v, (i == NENT - 1) ? 32'd3 : 32'd0);
    end
    chk("R8 head wrapped", mh, BASE);
    chk("R6 irq on full", {31'b0, irq}, 32'd1);

    // R7: writes to a full queue are refused
    @(negedge clk); bus_req = 1'b1; bus_wdata = 32'hDEAD_BEEF;
    for (int k = 0; k < 5; k++) begin
      #1; chk("R7 full retry", {30'b0, bus_retry, bus_ack}, 32'd2);
      @(negedge clk);
    end
    bus_req = 1'b0; #1;
    rd(2'd0, v); chk("R7 head unchanged", v, BASE);
    chk("R7 memory unchanged", mem[0], 32'hA500_0000);

    wr(2'd0, BASE);
    wr(2'd1, BASE);
    rd(2'd2, v); chk("R5 pointer writes keep status", v, 32'd3);
    mt = BASE + 4; wr(2'd1, mt);
    rd(2'd2, v); chk("R10 tail move clears full flag", v, 32'd1);
    push(32'h1111_2222, 2);
    rd(2'd2, v); chk("R4 full again", v, 32'd3);
    chk("R8 wrapped write at base", mem[0], 32'h1111_2222);

    wr(2'd2, 32'd1);
    rd(2'd2, v); chk("R5 write-one clears event", v, 32'd2);
    chk("R6 irq low after clear", {31'b0, irq}, 32'd0);
    wr(2'd3, 32'd1);
    mt = BASE + 8; wr(2'd1, mt);
    push(32'h3333_4444, 0);
    rd(2'd2, v); chk("R6 masked event recorded", v, 32'd3);
    chk("R6 irq masked", {31'b0, irq}, 32'd0);
    wr(2'd3, 32'd0);
    chk("R6 irq after unmask", {31'b0, irq}, 32'd1);

    mt = BASE + 32'h20; wr(2'd1, mt);
    wr(2'd0, 32'hFFFF_FF13);
    rd(2'd0, v); chk("R8 head load fitted", v, BASE + 32'h10);
    mh = BASE + 32'h10;
    push(32'h5555_6666, 3);
    chk("R9 loaded head used", mem[4], 32'h5555_6666);
    rd(2'd1, v); chk("R10 tail untouched by pushes", v, mt);
    rd(2'd2, v); chk("R12 status map", v, 32'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule